// File: doc/BRIEF.md
# Prioritised Multi-Level Interrupt Controller

This block collects up to 32 interrupt request lines and reduces them to a single number: the most urgent priority level that is both pending and enabled and that outranks the processor's current interrupt threshold. Each line has a fixed kind and a fixed priority, both set by parameters. The kind is one of level, edge, non-maskable (NMI), software, timer, debug or write-error. The priority is a level from 1 to `NUM_LEVELS` (at most 6). NMI lines always sit one level above the highest configurable one.

Two registers hold the state: a pending register and an enable register. Pending bits are set by the raw request lines. Software can also set them through a set-write port and clear them through a clear-write port, but each port acts only on the line kinds it is allowed to touch. A level-kind line mirrors its wire. Every other kind latches once it is raised. Software replaces the enable register as a whole.

The result is computed from the state after the current cycle's updates and the current threshold. It is then registered, so the output shows a change one clock after the cycle that caused it. Exception entry and vector selection are left to the processor.

Top module: `pic_top`

## Requirements
- R1: After reset the pending and enable registers are all zero and `pend_level` is 0.
- R2: The pending bit of a level-kind line (kind code 0) equals the value its request input had at the previous clock edge. Neither write port affects it.
- R3: A high request input on a line of kind edge (1), NMI (2), software (3), timer (4), debug (5) or write-error (6) sets its pending bit. The bit stays set after the input falls.
- R4: Bits of `irq_in`, `set_bits`, `clr_bits` and `en_bits` at index `NUM_LINES` and above have no effect.
- R5: A set-write (`set_we` high) sets pending only for software-kind lines. The bits it carries for every other kind are dropped.
- R6: A clear-write (`clr_we` high) clears pending only for edge, NMI and software lines. Timer, debug and write-error bits are unaffected, and level-kind bits keep following their wire. If a line's request input is high, or a set-write for that line arrives in the same cycle, the bit stays set.
- R7: `pend_level` is the highest level L for which both hold: L is greater than `cur_level`, and some line at level L is pending and enabled. If no level qualifies, `pend_level` is 0. NMI lines have level `NUM_LEVELS`+1, which is 7 by default. With the default configuration, lines 0 to 11 have kind/level: 0 timer/4, 1 level/1, 2 edge/2, 3 software/3, 4 level/5, 5 edge/6, 6 NMI/7, 7 software/1, 8 debug/6, 9 write-error/2, 10 level/3, 11 edge/5.
- R8: An enable write (`en_we` high) replaces the whole enable register with `en_bits`.
- R9: `pend_level` reflects changes in request inputs, writes and `cur_level` one clock edge after the cycle in which they are applied. There is no combinational path from inputs to the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw request lines, one per interrupt line |
| cur_level | input | 3 | Processor's current interrupt level (threshold) |
| set_we | input | 1 | Set-write strobe for the pending register |
| set_bits | input | 32 | Bits to set in the pending register |
| clr_we | input | 1 | Clear-write strobe for the pending register |
| clr_bits | input | 32 | Bits to clear in the pending register |
| en_we | input | 1 | Enable register write strobe |
| en_bits | input | 32 | New enable register value |
| pend_level | output | 3 | Highest qualifying pending level, 0 if none |

## Verification
The internal state can only be seen through `pend_level`. A pending or enable bit that is wrong shows up as a wrong level one clock later, but only while that line is enabled and its level is the highest one above the threshold. The bench therefore drives the threshold and the enable mask so that each line it probes is the top candidate. A latch that fails to hold, or clears when it should not, appears when the bench later lowers competing levels. A reference model that runs every cycle catches divergences under random traffic within one cycle of the point where they become visible.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int MAX_LINES = 32;
  localparam int KIND_W    = 3;
  localparam int PRIO_W    = 3;
  localparam int LVL_SLOTS = 1 << PRIO_W;

  typedef enum logic [KIND_W-1:0] {
    K_LEVEL = 3'd0,
    K_EDGE  = 3'd1,
    K_NMI   = 3'd2,
    K_SOFT  = 3'd3,
    K_TIMER = 3'd4,
    K_DEBUG = 3'd5,
    K_WERR  = 3'd6
  } irq_kind_e;

  // Lines below the configured count
  function automatic logic [MAX_LINES-1:0] line_mask(input int n);
    logic [MAX_LINES-1:0] m;
    for (int i = 0; i < MAX_LINES; i++) m[i] = (i < n);
    return m;
  endfunction

  // Lines of one kind
  function automatic logic [MAX_LINES-1:0] kind_mask(
    input logic [KIND_W*MAX_LINES-1:0] kinds, input int n, input irq_kind_e k);
    logic [MAX_LINES-1:0] m;
    for (int i = 0; i < MAX_LINES; i++)
      m[i] = (i < n) && (kinds[KIND_W*i +: KIND_W] == k);
    return m;
  endfunction

  // Lines whose effective priority equals lvl; NMI lines sit at top
  function automatic logic [MAX_LINES-1:0] prio_mask(
    input logic [KIND_W*MAX_LINES-1:0] kinds,
    input logic [PRIO_W*MAX_LINES-1:0] prios,
    input int n, input int top, input int lvl);
    logic [MAX_LINES-1:0] m;
    int p;
    for (int i = 0; i < MAX_LINES; i++) begin
      p = (kinds[KIND_W*i +: KIND_W] == K_NMI) ? top : int'(prios[PRIO_W*i +: PRIO_W]);
      m[i] = (i < n) && (p == lvl);
    end
    return m;
  endfunction

  // Highest set slot above 0, or 0
  function automatic logic [PRIO_W-1:0] top_hit(input logic [LVL_SLOTS-1:0] hits);
    logic [PRIO_W-1:0] r;
    r = '0;
    for (int l = 1; l < LVL_SLOTS; l++)
      if (hits[l]) r = PRIO_W'(l);
    return r;
  endfunction
endpackage

// File: rtl/pic_line_bank.sv
module pic_line_bank
  import pic_pkg::*;
#(
  parameter int NUM_LINES = 12,
  parameter logic [KIND_W*MAX_LINES-1:0] LINE_KINDS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MAX_LINES-1:0] irq_in,
  input  logic                 set_we,
  input  logic [MAX_LINES-1:0] set_bits,
  input  logic                 clr_we,
  input  logic [MAX_LINES-1:0] clr_bits,
  input  logic                 en_we,
  input  logic [MAX_LINES-1:0] en_bits,
  output logic [MAX_LINES-1:0] pend_q,
  output logic [MAX_LINES-1:0] en_q,
  output logic [MAX_LINES-1:0] pend_d,
  output logic [MAX_LINES-1:0] en_d
);
  localparam logic [MAX_LINES-1:0] LMASK = line_mask(NUM_LINES);
  localparam logic [MAX_LINES-1:0] TRACK = kind_mask(LINE_KINDS, NUM_LINES, K_LEVEL);
  localparam logic [MAX_LINES-1:0] SOFT  = kind_mask(LINE_KINDS, NUM_LINES, K_SOFT);
  localparam logic [MAX_LINES-1:0] CLRBL = kind_mask(LINE_KINDS, NUM_LINES, K_EDGE)
                                         | kind_mask(LINE_KINDS, NUM_LINES, K_NMI)
                                         | SOFT;

  logic [MAX_LINES-1:0] raw_next;
  logic [MAX_LINES-1:0] sw_set;
  logic [MAX_LINES-1:0] sw_clr;

  assign sw_set = set_we ? (set_bits & SOFT)  : '0;
  assign sw_clr = clr_we ? (clr_bits & CLRBL) : '0;

  for (genvar i = 0; i < MAX_LINES; i++) begin : g_line
    if (TRACK[i]) begin : g_track
      assign raw_next[i] = irq_in[i];
    end else begin : g_latch
      assign raw_next[i] = (pend_q[i] & ~sw_clr[i]) | irq_in[i] | sw_set[i];
    end
  end

  assign pend_d = raw_next & LMASK;
  assign en_d   = en_we ? (en_bits & LMASK) : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
  import pic_pkg::*;
#(
  parameter int NUM_LINES  = 12,
  parameter int NUM_LEVELS = 6,
  parameter logic [KIND_W*MAX_LINES-1:0] LINE_KINDS = '0,
  parameter logic [PRIO_W*MAX_LINES-1:0] LINE_PRIOS = '0
) (
  input  logic [MAX_LINES-1:0] active,
  input  logic [PRIO_W-1:0]    cur_level,
  output logic [LVL_SLOTS-1:0] level_hit,
  output logic [PRIO_W-1:0]    best
);
  localparam int TOP = NUM_LEVELS + 1;

  for (genvar l = 0; l < LVL_SLOTS; l++) begin : g_lvl
    if (l >= 1 && l <= TOP) begin : g_used
      localparam logic [MAX_LINES-1:0] M = prio_mask(LINE_KINDS, LINE_PRIOS, NUM_LINES, TOP, l);
      assign level_hit[l] = (|(active & M)) && (cur_level < PRIO_W'(l));
    end else begin : g_none
      assign level_hit[l] = 1'b0;
    end
  end

  assign best = top_hit(level_hit);
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int NUM_LINES  = 12,
  parameter int NUM_LEVELS = 6,
  parameter logic [KIND_W*MAX_LINES-1:0] LINE_KINDS =
    {{20{3'd0}}, 3'd1, 3'd0, 3'd6, 3'd5, 3'd3, 3'd2, 3'd1, 3'd0, 3'd3, 3'd1, 3'd0, 3'd4},
  parameter logic [PRIO_W*MAX_LINES-1:0] LINE_PRIOS =
    {{20{3'd1}}, 3'd5, 3'd3, 3'd2, 3'd6, 3'd1, 3'd7, 3'd6, 3'd5, 3'd3, 3'd2, 3'd1, 3'd4}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MAX_LINES-1:0] irq_in,
  input  logic [PRIO_W-1:0]    cur_level,
  input  logic                 set_we,
  input  logic [MAX_LINES-1:0] set_bits,
  input  logic                 clr_we,
  input  logic [MAX_LINES-1:0] clr_bits,
  input  logic                 en_we,
  input  logic [MAX_LINES-1:0] en_bits,
  output logic [PRIO_W-1:0]    pend_level
);
  logic [MAX_LINES-1:0] pend_q, en_q, pend_d, en_d, active;
  logic [LVL_SLOTS-1:0] level_hit;
  logic [PRIO_W-1:0]    best;
  logic [PRIO_W-1:0]    pend_level_q;

  pic_line_bank #(.NUM_LINES(NUM_LINES), .LINE_KINDS(LINE_KINDS)) u_bank (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .set_we(set_we), .set_bits(set_bits),
    .clr_we(clr_we), .clr_bits(clr_bits),
    .en_we(en_we), .en_bits(en_bits),
    .pend_q(pend_q), .en_q(en_q), .pend_d(pend_d), .en_d(en_d)
  );

  // Evaluate on the post-update state so the output lags by one edge
  assign active = pend_d & en_d;

  pic_prio_resolve #(
    .NUM_LINES(NUM_LINES), .NUM_LEVELS(NUM_LEVELS),
    .LINE_KINDS(LINE_KINDS), .LINE_PRIOS(LINE_PRIOS)
  ) u_resolve (
    .active(active), .cur_level(cur_level), .level_hit(level_hit), .best(best)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_level_q <= '0;
    else        pend_level_q <= best;
  end

  assign pend_level = pend_level_q;
endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
#(
  parameter int NUM_LINES = 12,
  parameter logic [KIND_W*MAX_LINES-1:0] LINE_KINDS = '0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [MAX_LINES-1:0] irq_in,
  input logic [PRIO_W-1:0]    cur_level,
  input logic                 clr_we,
  input logic [MAX_LINES-1:0] clr_bits,
  input logic                 en_we,
  input logic [MAX_LINES-1:0] en_bits,
  input logic [MAX_LINES-1:0] pend_q,
  input logic [MAX_LINES-1:0] en_q,
  input logic [MAX_LINES-1:0] active,
  input logic [PRIO_W-1:0]    pend_level
);
  localparam logic [MAX_LINES-1:0] LMASK  = line_mask(NUM_LINES);
  localparam logic [MAX_LINES-1:0] TRACK  = kind_mask(LINE_KINDS, NUM_LINES, K_LEVEL);
  localparam logic [MAX_LINES-1:0] SOFT   = kind_mask(LINE_KINDS, NUM_LINES, K_SOFT);
  localparam logic [MAX_LINES-1:0] STICKY = kind_mask(LINE_KINDS, NUM_LINES, K_TIMER)
                                          | kind_mask(LINE_KINDS, NUM_LINES, K_DEBUG)
                                          | kind_mask(LINE_KINDS, NUM_LINES, K_WERR);
  localparam logic [MAX_LINES-1:0] HOLD   = LMASK & ~TRACK;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_track_r2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (pend_q & TRACK) == ($past(irq_in) & TRACK));

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (($past(pend_q) & HOLD & ~($past(clr_we) ? $past(clr_bits) : '0)) & ~pend_q) == '0);

  p_set_soft_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (pend_q & ~$past(pend_q) & ~$past(irq_in) & ~SOFT) == '0);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ($past(pend_q) & STICKY & ~pend_q) == '0);

  p_above_cur_r7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (pend_level != '0) |-> (pend_level > $past(cur_level)));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ($past(active) == '0) |-> (pend_level == '0));

  p_enable_r8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(en_we) |-> (en_q == ($past(en_bits) & LMASK)));
endmodule

bind pic_top pic_checker #(.NUM_LINES(NUM_LINES), .LINE_KINDS(LINE_KINDS)) u_pic_checker (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cur_level(cur_level),
  .clr_we(clr_we), .clr_bits(clr_bits), .en_we(en_we), .en_bits(en_bits),
  .pend_q(pend_q), .en_q(en_q), .active(active), .pend_level(pend_level)
);

// File: tb/test_pic_top.sv
`timescale 1ns/1ps
module test_pic_top;
  localparam int NL = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0, set_bits = '0, clr_bits = '0, en_bits = '0;
  logic        set_we = 1'b0, clr_we = 1'b0, en_we = 1'b0;
  logic [2:0]  cur_level = '0;
  logic [2:0]  pend_level;

  always #2 clk = ~clk;

  pic_top i_pic_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cur_level(cur_level),
    .set_we(set_we), .set_bits(set_bits), .clr_we(clr_we), .clr_bits(clr_bits),
    .en_we(en_we), .en_bits(en_bits), .pend_level(pend_level)
  );

  int checks = 0, fails = 0;
  string tag = "R1";

  // Reference model: 0 level,1 edge,2 nmi,3 soft,4 timer,5 debug,6 write-error
  int m_kind[NL] = '{4, 0, 1, 3, 0, 1, 2, 3, 5, 6, 0, 1};
  int m_prio[NL] = '{4, 1, 2, 3, 5, 6, 7, 1, 6, 2, 3, 5};
  bit m_pend[NL];
  bit m_en[NL];
  int m_exp = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_en[i] = 0; end
      m_exp = 0;
    end else begin
      for (int i = 0; i < NL; i++) begin
        if (m_kind[i] == 0) m_pend[i] = irq_in[i];
        else begin
          if (clr_we && clr_bits[i] && m_kind[i] inside {1, 2, 3}) m_pend[i] = 0;
          if (irq_in[i]) m_pend[i] = 1;
          if (set_we && set_bits[i] && m_kind[i] == 3) m_pend[i] = 1;
        end
      end
      if (en_we) for (int i = 0; i < NL; i++) m_en[i] = en_bits[i];
      m_exp = 0;
      for (int lv = 7; lv >= 1; lv--)
        if (m_exp == 0 && lv > int'(cur_level))
          for (int i = 0; i < NL; i++)
            if (m_pend[i] && m_en[i] && m_prio[i] == lv) m_exp = lv;
    end
  end

  function automatic void check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: pend_level=%0d expected %0d at %0t", t, act, exp, $time);
    end
  endfunction

  // Model comparison every cycle
  always @(negedge clk) if (rst_n) check({tag, " model"}, int'(pend_level), m_exp);

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_in = '0; set_we = 0; clr_we = 0; en_we = 0; cur_level = '0;
    repeat (2) cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic wr_en(input logic [31:0] v);
    en_we = 1; en_bits = v; cyc(); en_we = 0;
  endtask
  task automatic wr_set(input logic [31:0] v);
    set_we = 1; set_bits = v; cyc(); set_we = 0;
  endtask
  task automatic wr_clr(input logic [31:0] v);
    clr_we = 1; clr_bits = v; cyc(); clr_we = 0;
  endtask
  task automatic pulse_irq(input int i);
    irq_in[i] = 1'b1; cyc(); irq_in[i] = 1'b0; cyc();
  endtask

  initial begin
    do_reset();
    tag = "R1"; check("R1 reset", int'(pend_level), 0);
    tag = "R8"; wr_en(32'hFFFF_FFFF); check("R8 enable only", int'(pend_level), 0);

    tag = "R4";
    irq_in = 32'hFFFF_F000; cyc(); check("R4 stray lines", int'(pend_level), 0);
    irq_in = '0;
    wr_set(32'hFFFF_F000); check("R4 stray set", int'(pend_level), 0);

    tag = "R2";
    irq_in[1] = 1'b1; #1 check("R9 no comb path", int'(pend_level), 0);
    cyc(); check("R2 level high", int'(pend_level), 1);
    irq_in[1] = 1'b0; cyc(); check("R2 level drop", int'(pend_level), 0);

    tag = "R3";
    pulse_irq(2); check("R3 edge latched", int'(pend_level), 2);
    cyc(); check("R3 edge still latched", int'(pend_level), 2);
    wr_clr(32'h4); check("R6 clear edge", int'(pend_level), 0);

    tag = "R5";
    wr_set(32'hFFFF_FFFF); check("R5 set soft only", int'(pend_level), 3);
    wr_clr(32'h8); check("R5 non-soft untouched", int'(pend_level), 1);
    wr_clr(32'h80); check("R6 clear soft", int'(pend_level), 0);

    tag = "R6";
    set_we = 1; set_bits = 32'h8; clr_we = 1; clr_bits = 32'h8; cyc();
    set_we = 0; clr_we = 0;
    check("R6 set wins over clear", int'(pend_level), 3);

    tag = "R7";
    cur_level = 3'd3; cyc(); check("R7 at threshold", int'(pend_level), 0);
    cur_level = 3'd2; cyc(); check("R7 above threshold", int'(pend_level), 3);
    cur_level = 3'd6; pulse_irq(6); check("R7 nmi above 6", int'(pend_level), 7);
    cur_level = 3'd7; cyc(); check("R7 all masked", int'(pend_level), 0);
    cur_level = 3'd0; cyc(); check("R7 nmi wins", int'(pend_level), 7);
    wr_clr(32'h40); check("R7 next lower", int'(pend_level), 3);

    tag = "R8";
    wr_en(32'h0); check("R8 disable all", int'(pend_level), 0);
    wr_en(32'h8); check("R8 replace", int'(pend_level), 3);
    wr_en(32'hFFF);

    tag = "R6";
    wr_clr(32'h8);
    pulse_irq(0); check("R3 timer latched", int'(pend_level), 4);
    wr_clr(32'h1); check("R6 timer not cleared", int'(pend_level), 4);
    irq_in[4] = 1'b1; cyc(); check("R2 level line", int'(pend_level), 5);
    wr_clr(32'h10); check("R6 level ignores clear", int'(pend_level), 5);
    irq_in[4] = 1'b0; cyc(); check("R2 level falls", int'(pend_level), 4);

    do_reset(); tag = "R1"; check("R1 reset clears sticky", int'(pend_level), 0);

    tag = "R7";
    for (int n = 0; n < 3000; n++) begin
      if (n % 500 == 499) begin do_reset(); tag = "R7"; end
      irq_in   = $urandom & $urandom & $urandom;
      set_we   = ($urandom % 4) == 0; set_bits = $urandom;
      clr_we   = ($urandom % 3) == 0; clr_bits = $urandom;
      en_we    = ($urandom % 8) == 0; en_bits  = $urandom;
      if ($urandom % 5 == 0) cur_level = 3'($urandom);
      cyc();
    end
    set_we = 0; clr_we = 0; en_we = 0; irq_in = '0;
    cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule